// File: doc/BRIEF.md
# I2C Pin Override for Bus Recovery

This unit sits between an I2C controller and the SCL/SDA pads. In normal operation it hands the controller's open-drain pull-down requests straight to the pads. When software sets a single mode bit, both lines are taken away from the controller together. They then behave as two general-purpose pins. Each pin has a direction bit, a latched output value, and a synchronized input sample. Software can use this to clock a stuck target free by toggling SCL while watching SDA.

Software changes the output latch in one of three ways. It can write the latch directly, write 1s to a set register, or write 1s to a clear register. The set and clear registers let software move one pin without a read-modify-write of the other. Pins are open-drain in both modes. A latched high releases the line. A latched low on a pin configured as output pulls it down. Bit 0 of every pin-related field is SCL and bit 1 is SDA.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset the mode bit is 0, both direction bits are 0, the output latch reads 2'b11, and the pads follow the controller.
- R2: With the mode bit at 0, `pin_oe` equals `eng_low` for each line, whatever the direction and latch values are.
- R3: With the mode bit at 1, `pin_oe[i]` is 1 only when direction bit i is 1 and latch bit i is 0. Changes on `eng_low` have no effect on the pads in this mode.
- R4: A write to the set register (offset 0x10) sets every latch bit written as 1. Bits written as 0 keep their value.
- R5: A write to the clear register (offset 0x14) clears every latch bit written as 1. Bits written as 0 keep their value.
- R6: A write to the output register (offset 0x0C) loads bits [1:0] into the latch. A read of that register returns the latch.
- R7: The input register (offset 0x08) returns {SDA, SCL} pad levels through a two-flop synchronizer. A pad change driven before rising edge k is first visible after rising edge k+1.
- R8: The direction register (offset 0x04) holds {SDA, SCL} output enables and reads back as written. A pin whose direction bit is 0 is released even when its latch bit is 0.
- R9: The mode register (offset 0x00) stores only bit 0. Its other bits read 0, and the set and clear registers read 0.
- R10: Writes to the input register or to an unmapped offset change neither the mode, the direction, nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| eng_low | input | 2 | Controller pull-down requests {SDA, SCL} |
| pin_in | input | 2 | Pad levels {SDA, SCL} |
| pin_oe | output | 2 | Pad pull-down enables {SDA, SCL}, 1 drives low |
| pin_o | output | 2 | Pad drive data, always 0 (open drain) |

## Verification
A stimulus table applies set, clear and direct-write patterns to the latch with both lines configured as outputs. It then narrows the direction so that SDA stays released with a low latch. Because the set and clear patterns include all-zero writes, a design that touches unwritten bits is exposed. Toggling `eng_low` while in GPIO mode, and then leaving that mode, tells controller pass-through apart from GPIO drive. Directed tests check the reset values, the exact two-edge synchronizer delay, the masking of the mode register's upper bits, and writes to read-only or unmapped offsets.

// File: rtl/i2c_pin_override.sv
module i2c_pin_override #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h04,
  parameter logic [ADDR_W-1:0] DIN_ADDR  = 'h08,
  parameter logic [ADDR_W-1:0] DOUT_ADDR = 'h0C,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 'h10,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        eng_low,
  input  logic [1:0]        pin_in,
  output logic [1:0]        pin_oe,
  output logic [1:0]        pin_o
);

  logic       mode_q;
  logic [1:0] dir_q, dout_q, meta_q, din_q, age_q;
  logic [1:0] wbits;
  logic       unused_bits;

  assign wbits       = reg_wdata[1:0];
  assign unused_bits = ^reg_wdata[DATA_W-1:2];

  wire hit_mode = reg_wr && (reg_addr == MODE_ADDR);
  wire hit_dir  = reg_wr && (reg_addr == DIR_ADDR);
  wire hit_dout = reg_wr && (reg_addr == DOUT_ADDR);
  wire hit_set  = reg_wr && (reg_addr == SET_ADDR);
  wire hit_clr  = reg_wr && (reg_addr == CLR_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      dir_q  <= 2'b00;
      dout_q <= 2'b11;
    end else begin
      if (hit_mode) mode_q <= wbits[0];
      if (hit_dir)  dir_q  <= wbits;
      if (hit_dout)     dout_q <= wbits;
      else if (hit_set) dout_q <= dout_q | wbits;
      else if (hit_clr) dout_q <= dout_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 2'b00;
      din_q  <= 2'b00;
      age_q  <= 2'd0;
    end else begin
      meta_q <= pin_in;
      din_q  <= meta_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == MODE_ADDR)      reg_rdata[0]   = mode_q;
    else if (reg_addr == DIR_ADDR)  reg_rdata[1:0] = dir_q;
    else if (reg_addr == DIN_ADDR)  reg_rdata[1:0] = din_q;
    else if (reg_addr == DOUT_ADDR) reg_rdata[1:0] = dout_q;
  end

  assign pin_oe = mode_q ? (dir_q & ~dout_q) : eng_low;
  assign pin_o  = 2'b00;

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> dout_q == ($past(dout_q) | $past(wbits)));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> dout_q == ($past(dout_q) & ~$past(wbits)));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> din_q == $past(pin_in, 2));

  assert_oe_needs_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (pin_oe & ~dir_q) == 2'b00);

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == DIN_ADDR) |=> $stable(dout_q) && $stable(dir_q) && $stable(mode_q));

endmodule

// File: tb/i2c_pin_override_bench.sv
module i2c_pin_override_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [1:0]  eng_low = 2'b00;
  logic [1:0]  pin_in = 2'b00;
  logic [1:0]  pin_oe, pin_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_pin_override u_i2c_pin_override (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_low(eng_low),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_o(pin_o));

  // {addr[7:0], wdata[3:0], eng_low[1:0], exp_latch[1:0], exp_oe[1:0]}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {8'h14, 4'h1, 2'b00, 2'b10, 2'b01},  // R5 clear SCL
    {8'h14, 4'h2, 2'b11, 2'b00, 2'b11},  // R5 clear SDA, R3 engine ignored
    {8'h10, 4'h1, 2'b00, 2'b01, 2'b10},  // R4 set SCL
    {8'h10, 4'h0, 2'b11, 2'b01, 2'b10},  // R4 zero write no effect
    {8'h14, 4'h0, 2'b00, 2'b01, 2'b10},  // R5 zero write no effect
    {8'h0C, 4'h2, 2'b00, 2'b10, 2'b01},  // R6 direct load
    {8'h10, 4'h3, 2'b11, 2'b11, 2'b00},  // R4 set both
    {8'h04, 4'h1, 2'b00, 2'b11, 2'b00},  // R8 SDA becomes input
    {8'h14, 4'h3, 2'b00, 2'b00, 2'b01},  // R8 SDA released while latch low
    {8'h08, 4'h3, 2'b00, 2'b00, 2'b01},  // R10 input register write ignored
    {8'h00, 4'h0, 2'b10, 2'b00, 2'b10},  // R2 back to controller
    {8'h3C, 4'h1, 2'b01, 2'b00, 2'b01}   // R10 unmapped write, R2 follow
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 mode", r, 16'h0);
    rd(8'h04, r); check("R1 dir", r, 16'h0);
    rd(8'h0C, r); check("R1 latch", r, 16'h3);
    eng_low = 2'b01; #1 check("R1 follow", {14'h0, pin_oe}, 16'h1);
    check("R1 pin_o", {14'h0, pin_o}, 16'h0);

    // R9 mode upper bits and write-only reads
    wr(8'h00, 16'hFFFF);
    rd(8'h00, r); check("R9 mode mask", r, 16'h1);
    rd(8'h10, r); check("R9 set reads 0", r, 16'h0);
    rd(8'h14, r); check("R9 clr reads 0", r, 16'h0);
    wr(8'h04, 16'h0003);
    rd(8'h04, r); check("R8 dir readback", r, 16'h3);

    for (int i = 0; i < NV; i++) begin
      eng_low = VEC[i][5:4];
      wr(VEC[i][17:10], {12'h0, VEC[i][9:6]});
      rd(8'h0C, r); check($sformatf("R4/R5/R6 latch vec%0d", i), r, {14'h0, VEC[i][3:2]});
      check($sformatf("R2/R3 oe vec%0d", i), {14'h0, pin_oe}, {14'h0, VEC[i][1:0]});
    end
    rd(8'h04, r); check("R10 dir kept", r, 16'h1);

    // R7 synchronizer latency
    @(negedge clk); pin_in = 2'b10;
    @(negedge clk); rd(8'h08, r); check("R7 not yet", r, 16'h0);
    @(negedge clk); rd(8'h08, r); check("R7 visible", r, 16'h2);
    pin_in = 2'b01;
    @(negedge clk); @(negedge clk); rd(8'h08, r); check("R7 SCL high", r, 16'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule